// File: doc/BRIEF.md
# Variable-duty pulse tone channel

The block is one square-wave voice of a retro sound generator. A CPU writes four byte-wide registers: a control register holding the duty selection and the fields that the envelope and length units consume, a sweep register that this block does not use, and two period registers. These set an 11-bit period `t`. A divide-by-two toggle advances a down-counting timer on every second clock. Each time the timer wraps from 0 back to `t`, it steps an 8-position duty sequencer. The resulting waveform repeats every `16*(t+1)` clocks.

The 4-bit sample output passes the volume from an external envelope unit while the current duty bit is high. Four conditions force it to zero: a low duty bit, a muting request from the sweep unit, an exhausted length counter, and a period below eight. Writing the high period byte restarts the duty sequence at its first position. The same write sends one-cycle restart and load pulses, together with a 5-bit length index, to the neighbouring envelope and length units. It leaves the running period count as it is.

Top module: `pulse_tone_channel`

## Requirements
- R1: A synchronous reset forces the following state: `sample_out` is 0, `env_restart` and `len_load` are 0, and `ctl_halt`, `ctl_const_vol` and `ctl_vol_field` are 0.
- R2: The period `t` is 11 bits wide. Index 2 supplies bits 7:0 and bits 2:0 of index 3 supply bits 10:8. With all gates open, the waveform repeats every `16*(t+1)` clocks.
- R3: Control bits 7:6 select the duty. Each sequencer clock moves the 3-bit step downward from 0, so table positions are visited in the order 0,7,6,5,4,3,2,1. Duty 0/1/2/3 keep the output high for 1/2/4/6 contiguous steps of the cycle, each step lasting `2*(t+1)` clocks. In visit order the patterns are 01000000, 01100000, 01111000 and 10011111.
- R4: A write to index 3 moves the step to position 0 on the next clock edge. It does not restart the timer's count: the next sequencer step still arrives at the old reload phase.
- R5: A write to index 0 changes the duty selection without moving the step position.
- R6: From a write to index 0, `ctl_halt` shows bit 5, `ctl_const_vol` shows bit 4 and `ctl_vol_field` shows bits 3:0.
- R7: A write to index 3 raises `env_restart` and `len_load` for exactly one cycle, and `len_index` carries bits 7:3 of the written byte.
- R8: A period below 8 (t = 0..7) holds `sample_out` at 0. A period of 8 produces sound.
- R9: While `sweep_mute` is 1, `sample_out` is 0.
- R10: While `len_nonzero` is 0, `sample_out` is 0.
- R11: When no gate applies and the duty bit is 1, `sample_out` equals `env_vol`.
- R12: A write to index 1 changes none of the outputs: the control fields stay as they were and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index: 0 control, 1 sweep (ignored), 2 period low, 3 period high |
| wr_data | input | 8 | Write data |
| env_vol | input | 4 | Volume from the envelope unit |
| len_nonzero | input | 1 | Length counter is not zero |
| sweep_mute | input | 1 | Sweep overflow mute request |
| sample_out | output | 4 | Gated sample to the mixer |
| ctl_halt | output | 1 | Control bit 5, for the length unit |
| ctl_const_vol | output | 1 | Control bit 4, for the envelope unit |
| ctl_vol_field | output | 4 | Control bits 3:0, for the envelope unit |
| env_restart | output | 1 | One-cycle envelope restart pulse |
| len_load | output | 1 | One-cycle length load pulse |
| len_index | output | 5 | Length load index (high byte bits 7:3) |

## Verification
The bench builds the block with its default 11-bit period, 8-bit data path and a silence threshold of eight. With these values, a period of 300 drives the high period bits. The whole silent band 0..7 can be swept, and its edge at 8 checked, in a few hundred clocks per value. The monitor times full waveform cycles from rising edge to rising edge for all four duties. A second check, made after aligning to a sequencer step, shows that the next step still lands at the old reload phase after a high-byte write.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

    typedef enum logic [1:0] {
        IDX_CTRL  = 2'd0,
        IDX_SWEEP = 2'd1,
        IDX_PLO   = 2'd2,
        IDX_PHI   = 2'd3
    } reg_idx_e;

    localparam int STEP_W = 3;
    localparam int STEPS  = 1 << STEP_W;

    // Duty lookup, bit n is the level at step position n.
    function automatic logic [STEPS-1:0] duty_lut(input logic [1:0] duty);
        logic [STEPS-1:0] lut;
        case (duty)
            2'd0:    lut = 8'b1000_0000;
            2'd1:    lut = 8'b1100_0000;
            2'd2:    lut = 8'b1111_0000;
            default: lut = 8'b0011_1111;
        endcase
        return lut;
    endfunction

endpackage

// File: rtl/pulse_regs.sv
module pulse_regs #(
    parameter int PERIOD_W = 11,
    parameter int DATA_W   = 8,
    parameter int VOL_W    = 4,
    localparam int HI_W    = PERIOD_W - DATA_W,
    localparam int LEN_W   = DATA_W - HI_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [1:0]          duty,
    output logic                halt,
    output logic                const_vol,
    output logic [VOL_W-1:0]    vol_field,
    output logic [PERIOD_W-1:0] period,
    output logic                hi_wr,
    output logic                env_restart,
    output logic                len_load,
    output logic [LEN_W-1:0]    len_index
);
    import pulse_pkg::*;

    typedef struct packed {
        logic [1:0]          duty;
        logic                halt;
        logic                cvol;
        logic [VOL_W-1:0]    vfield;
        logic [PERIOD_W-1:0] period;
        logic                env_rst;
        logic                len_ld;
        logic [LEN_W-1:0]    len_idx;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.env_rst = 1'b0;
        r_d.len_ld  = 1'b0;
        hi_wr       = 1'b0;
        if (wr_en) begin
            case (reg_idx_e'(wr_addr))
                IDX_CTRL: begin
                    r_d.duty   = wr_data[DATA_W-1 -: 2];
                    r_d.halt   = wr_data[5];
                    r_d.cvol   = wr_data[4];
                    r_d.vfield = wr_data[VOL_W-1:0];
                end
                IDX_SWEEP: begin
                    r_d = r_q;
                    r_d.env_rst = 1'b0;
                    r_d.len_ld  = 1'b0;
                end
                IDX_PLO: begin
                    r_d.period[DATA_W-1:0] = wr_data;
                end
                IDX_PHI: begin
                    r_d.period[PERIOD_W-1:DATA_W] = wr_data[HI_W-1:0];
                    r_d.len_idx = wr_data[DATA_W-1:HI_W];
                    r_d.env_rst = 1'b1;
                    r_d.len_ld  = 1'b1;
                    hi_wr       = 1'b1;
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign duty        = r_q.duty;
    assign halt        = r_q.halt;
    assign const_vol   = r_q.cvol;
    assign vol_field   = r_q.vfield;
    assign period      = r_q.period;
    assign env_restart = r_q.env_rst;
    assign len_load    = r_q.len_ld;
    assign len_index   = r_q.len_idx;

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int PERIOD_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    typedef struct packed {
        logic                half;
        logic [PERIOD_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    // The count reloads from the period register only at wrap,
    // so a new period never cuts short the count in progress.
    always_comb begin
        t_d      = t_q;
        tick     = 1'b0;
        t_d.half = ~t_q.half;
        if (t_q.half) begin
            if (t_q.cnt == '0) begin
                t_d.cnt = period;
                tick    = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

endmodule

// File: rtl/pulse_sequencer.sv
module pulse_sequencer
    import pulse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              restart,
    input  logic [1:0]        duty,
    output logic [STEP_W-1:0] step,
    output logic              level
);
    typedef struct packed {
        logic [STEP_W-1:0] pos;
    } seq_t;

    seq_t s_d, s_q;
    logic [STEPS-1:0] lut;

    always_comb begin
        s_d = s_q;
        if (restart)   s_d.pos = '0;
        else if (tick) s_d.pos = s_q.pos - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        lut   = duty_lut(duty);
        level = lut[s_q.pos];
    end

    assign step = s_q.pos;

endmodule

// File: rtl/pulse_tone_channel.sv
module pulse_tone_channel #(
    parameter int PERIOD_W   = 11,
    parameter int DATA_W     = 8,
    parameter int VOL_W      = 4,
    parameter int MIN_PERIOD = 8,
    localparam int HI_W      = PERIOD_W - DATA_W,
    localparam int LEN_W     = DATA_W - HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [VOL_W-1:0]  env_vol,
    input  logic              len_nonzero,
    input  logic              sweep_mute,
    output logic [VOL_W-1:0]  sample_out,
    output logic              ctl_halt,
    output logic              ctl_const_vol,
    output logic [VOL_W-1:0]  ctl_vol_field,
    output logic              env_restart,
    output logic              len_load,
    output logic [LEN_W-1:0]  len_index
);
    import pulse_pkg::*;

    logic [1:0]          duty_w;
    logic [PERIOD_W-1:0] period_w;
    logic                hi_wr_w;
    logic                tick_w;
    logic [STEP_W-1:0]   step_w;
    logic                level_w;
    logic                silent_w;

    pulse_regs #(
        .PERIOD_W (PERIOD_W),
        .DATA_W   (DATA_W),
        .VOL_W    (VOL_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .duty        (duty_w),
        .halt        (ctl_halt),
        .const_vol   (ctl_const_vol),
        .vol_field   (ctl_vol_field),
        .period      (period_w),
        .hi_wr       (hi_wr_w),
        .env_restart (env_restart),
        .len_load    (len_load),
        .len_index   (len_index)
    );

    pulse_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (period_w),
        .tick   (tick_w)
    );

    pulse_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .restart (hi_wr_w),
        .duty    (duty_w),
        .step    (step_w),
        .level   (level_w)
    );

    always_comb begin
        silent_w = !level_w || sweep_mute || !len_nonzero
                || (period_w < PERIOD_W'(MIN_PERIOD));
        sample_out = silent_w ? '0 : env_vol;
    end

endmodule

// File: rtl/pulse_tone_checker.sv
module pulse_tone_checker #(
    parameter int PERIOD_W   = 11,
    parameter int DATA_W     = 8,
    parameter int VOL_W      = 4,
    parameter int MIN_PERIOD = 8,
    parameter int STEP_W     = 3,
    localparam int HI_W      = PERIOD_W - DATA_W,
    localparam int LEN_W     = DATA_W - HI_W
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [VOL_W-1:0]    env_vol,
    input logic                len_nonzero,
    input logic                sweep_mute,
    input logic [VOL_W-1:0]    sample_out,
    input logic                env_restart,
    input logic                len_load,
    input logic [LEN_W-1:0]    len_index,
    input logic [PERIOD_W-1:0] period,
    input logic [STEP_W-1:0]   step,
    input logic                tick
);
    logic hi_write;
    assign hi_write = wr_en && (wr_addr == 2'd3);

    assert_short_period_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (period < PERIOD_W'(MIN_PERIOD)) |-> (sample_out == '0));

    assert_mute_silent_R9: assert property (@(posedge clk) disable iff (rst)
        sweep_mute |-> (sample_out == '0));

    assert_len_zero_silent_R10: assert property (@(posedge clk) disable iff (rst)
        !len_nonzero |-> (sample_out == '0));

    assert_out_is_volume_R11: assert property (@(posedge clk) disable iff (rst)
        (sample_out != '0) |-> (sample_out == env_vol));

    assert_restart_from_write_R7: assert property (@(posedge clk) disable iff (rst)
        env_restart |-> $past(hi_write));

    assert_len_index_R7: assert property (@(posedge clk) disable iff (rst)
        len_load |-> (len_index == $past(wr_data[DATA_W-1:HI_W])));

    assert_step_zero_after_hi_R4: assert property (@(posedge clk) disable iff (rst)
        $past(hi_write) |-> (step == '0));

    assert_step_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(hi_write) && !$past(tick)) |-> $stable(step));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(hi_write)) |-> (step == STEP_W'($past(step) - 1'b1)));

endmodule

bind pulse_tone_channel pulse_tone_checker #(
    .PERIOD_W   (PERIOD_W),
    .DATA_W     (DATA_W),
    .VOL_W      (VOL_W),
    .MIN_PERIOD (MIN_PERIOD),
    .STEP_W     (pulse_pkg::STEP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .env_vol     (env_vol),
    .len_nonzero (len_nonzero),
    .sweep_mute  (sweep_mute),
    .sample_out  (sample_out),
    .env_restart (env_restart),
    .len_load    (len_load),
    .len_index   (len_index),
    .period      (period_w),
    .step        (step_w),
    .tick        (tick_w)
);

// File: tb/pulse_tone_channel_test.sv
module pulse_tone_channel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] env_vol = '0;
    logic       len_nonzero = 1'b0;
    logic       sweep_mute = 1'b0;
    logic [3:0] sample_out;
    logic       ctl_halt;
    logic       ctl_const_vol;
    logic [3:0] ctl_vol_field;
    logic       env_restart;
    logic       len_load;
    logic [4:0] len_index;

    always #10 clk = ~clk;

    pulse_tone_channel uut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .env_vol       (env_vol),
        .len_nonzero   (len_nonzero),
        .sweep_mute    (sweep_mute),
        .sample_out    (sample_out),
        .ctl_halt      (ctl_halt),
        .ctl_const_vol (ctl_const_vol),
        .ctl_vol_field (ctl_vol_field),
        .env_restart   (env_restart),
        .len_load      (len_load),
        .len_index     (len_index)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    period;
        int    high;
    } exp_t;
    exp_t sb[$];

    bit mon_arm  = 1'b0;
    bit prev_on  = 1'b0;
    int rises    = 0;
    int mcnt     = 0;
    int mhi      = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_rise(output int waited);
        bit p;
        p = (sample_out != 0);
        waited = -1;
        for (int i = 1; i <= 2000; i++) begin
            @(negedge clk);
            if ((sample_out != 0) && !p) begin
                waited = i;
                break;
            end
            p = (sample_out != 0);
        end
    endtask

    // Monitor: ignores the first rising edge, opens a window at the second,
    // and scores the window against the queued item at the third.
    always @(negedge clk) begin
        bit on;
        exp_t e;
        if (!mon_arm) begin
            rises   = 0;
            prev_on = 1'b0;
        end else begin
            on = (sample_out != 0);
            if (on && !prev_on) begin
                rises++;
                if (rises >= 3 && sb.size() > 0) begin
                    e = sb.pop_front();
                    check(mcnt == e.period, "R2 waveform period", mcnt, e.period);
                    check(mhi == e.high, "R3 high time for duty", mhi, e.high);
                end
                mcnt = 1;
                mhi  = 1;
            end else begin
                mcnt++;
                if (on) mhi++;
            end
            prev_on = on;
        end
    end

    task automatic run_tone(input int d, input int t, input int ones);
        exp_t e;
        wr(2'd0, {d[1:0], 6'b0});
        wr(2'd2, t[7:0]);
        wr(2'd3, {5'd0, t[10:8]});
        e.period = 16 * (t + 1);
        e.high   = 2 * (t + 1) * ones;
        sb.push_back(e);
        mon_arm = 1'b1;
        while (sb.size() != 0) @(negedge clk);
        mon_arm = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_silence(input int cycles, input string req);
        int loud;
        loud = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_out != 0) loud++;
        end
        check(loud == 0, req, loud, 0);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sample_out == 0, "R1 sample_out", sample_out, 0);
        check(env_restart == 0 && len_load == 0, "R1 pulses", {env_restart, len_load}, 0);
        check({ctl_halt, ctl_const_vol, ctl_vol_field} == 0, "R1 control fields",
              {ctl_halt, ctl_const_vol, ctl_vol_field}, 0);
        rst = 1'b0;
        env_vol = 4'hF;
        len_nonzero = 1'b1;

        // R6 control fields
        wr(2'd0, 8'b10_1_0_1011);
        check({ctl_halt, ctl_const_vol, ctl_vol_field} == 6'b10_1011, "R6 fields a",
              {ctl_halt, ctl_const_vol, ctl_vol_field}, 6'b10_1011);
        wr(2'd0, 8'b01_0_1_0100);
        check({ctl_halt, ctl_const_vol, ctl_vol_field} == 6'b01_0100, "R6 fields b",
              {ctl_halt, ctl_const_vol, ctl_vol_field}, 6'b01_0100);

        // R12 sweep index ignored
        wr(2'd1, 8'hFF);
        check({ctl_halt, ctl_const_vol, ctl_vol_field} == 6'b01_0100, "R12 fields kept",
              {ctl_halt, ctl_const_vol, ctl_vol_field}, 6'b01_0100);
        check(env_restart == 0 && len_load == 0, "R12 no pulse", {env_restart, len_load}, 0);

        // R7 high byte pulses
        wr(2'd3, 8'b10110_000);
        check(env_restart == 1 && len_load == 1, "R7 pulses high", {env_restart, len_load}, 3);
        check(len_index == 5'b10110, "R7 len_index", len_index, 5'b10110);
        @(negedge clk);
        check(env_restart == 0 && len_load == 0, "R7 pulses one cycle", {env_restart, len_load}, 0);

        // R4 step restart, duty 3 starts high, duty 0 starts low
        wr(2'd0, 8'hC0);
        wr(2'd2, 8'd50);
        wr(2'd3, 8'd0);
        check(sample_out == 4'hF, "R4 duty3 first position", sample_out, 15);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'd0);
        check(sample_out == 0, "R4 duty0 first position", sample_out, 0);
        // R4 timer phase kept across a high-byte write
        wait_rise(w);
        check(w > 0, "R4 rise seen", w, 1);
        repeat (29) @(negedge clk);
        wr(2'd3, 8'd0);
        check(sample_out == 0, "R4 restart to position 0", sample_out, 0);
        wait_rise(w);
        check(w + 31 == 102, "R4 reload phase kept", w + 31, 102);

        // R5 control write keeps step (duty0 step7 high -> duty2 step7 high)
        wr(2'd2, 8'd20);
        wr(2'd3, 8'd0);
        wait_rise(w);
        wait_rise(w);
        wr(2'd0, 8'h80);
        check(sample_out == 4'hF, "R5 step kept on duty change", sample_out, 15);

        // R2 R3 waveform per duty
        run_tone(0, 8, 1);
        run_tone(1, 20, 2);
        run_tone(2, 300, 4);
        run_tone(3, 33, 6);

        // R11 volume passthrough
        env_vol = 4'h9;
        wr(2'd0, 8'h80);
        wr(2'd2, 8'd10);
        wr(2'd3, 8'd0);
        wait_rise(w);
        check(sample_out == 4'h9, "R11 output equals volume", sample_out, 9);
        env_vol = 4'hF;

        // R9 sweep mute
        wr(2'd0, 8'hC0);
        sweep_mute = 1'b1;
        expect_silence(300, "R9 mute silences");
        sweep_mute = 1'b0;

        // R10 length zero
        len_nonzero = 1'b0;
        expect_silence(300, "R10 length zero silences");
        len_nonzero = 1'b1;

        // R8 short periods
        for (int t = 0; t < 8; t++) begin
            wr(2'd2, t[7:0]);
            wr(2'd3, 8'd0);
            expect_silence(200, "R8 period below 8 silent");
        end
        wr(2'd2, 8'd8);
        wr(2'd3, 8'd0);
        wait_rise(w);
        check(w > 0, "R8 period 8 audible", w, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule